// File: doc/BRIEF.md
# Two-Group Rotating Bus Arbiter

This block arbitrates a shared, PCI-style parallel bus among up to ten masters. Master 0 is the bridge's own internal master; the others are external. A per-master control bit puts each master in a high or a low priority group. Inside each group, priority rotates. The whole low group holds a single position in the high group's rotation. With the bridge alone in the high group, the bridge therefore wins every other transaction, and the external masters take turns in the remaining slots.

Priorities are fixed between transaction starts. When FRAME# falls, the master holding the grant becomes the lowest-ranked member of its group. The low group has its own rotation pointer, and that pointer moves only when a low-group master starts. Between starts, the grant follows the highest-ranked active request. While the bus is busy, the grant may jump from one master to another in a single cycle. While FRAME# is high, a grant is held for at least two cycles, and one idle-grant cycle separates any two owners. A master that sits on an idle bus for sixteen cycles without starting loses its grant. It is then shut out until it releases its request.

Top module: `pci_dual_group_arbiter`

## Requirements
- R1: While reset is low, and in the first cycle after it with no request, every grant line is high (inactive).
- R2: At most one grant line is low at any time.
- R3: A control bit of 1 places master i in the high group and 0 places it in the low group. The low group as a whole takes one turn in the high group's rotation. With only master 0 high, master 0 and the low group alternate.
- R4: When every master is in the same group, the grant rotates in plain round-robin over masters 0 to 9 in ascending index order with wrap-around.
- R5: Ranking changes only in the cycle where FRAME# goes from high to low. The master granted in that cycle becomes lowest in its group, and the next index after it becomes highest. The low-group pointer moves only when a low-group master starts.
- R6: A higher-ranked request that appears while another master holds the grant takes the grant over.
- R7: While FRAME# is high, a newly asserted grant stays asserted for at least two cycles.
- R8: While FRAME# is high, a grant is never replaced by another in one cycle. The grant goes inactive for at least one cycle first.
- R9: While FRAME# is low, the grant may pass from one master to another in a single cycle.
- R10: A master that holds the grant for 16 consecutive cycles with both FRAME# and IRDY# high, without starting, loses the grant after the sixteenth such cycle.
- R11: A master that lost its grant this way gets no grant again until its request has been high (inactive) for at least one clock.
- R12: Any cycle with FRAME# or IRDY# low, or any change of owner, restarts the 16-cycle idle count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_n | input | 10 | Request lines, active low; bit 0 is the internal master |
| frame_n | input | 1 | Bus FRAME#, active low |
| irdy_n | input | 1 | Bus IRDY#, active low |
| hi_group | input | 10 | Group select per master, 1 = high group |
| gnt_n | output | 10 | Grant lines, active low |

## Verification
The bench targets the edges of the grant handover:
- A preemption on an idle bus must show an empty-grant cycle. A design that swapped owners directly would drive two masters onto the bus in adjacent cycles.
- The same swap while FRAME# is low must happen in one cycle. An over-cautious design would lose a cycle there.
- The idle timeout is probed with an IRDY# pulse in the middle of the count. A counter that failed to restart would withdraw the grant eleven cycles too early.
- The lockout is checked by re-requesting without a release cycle, and then with one.
- Rotation order is checked across starts in both groups. This shows that the low-group pointer moves only on low-group starts, and that a single-group setting reduces to plain round-robin with wrap-around.

// File: rtl/arb2g_pkg.sv
// Shared definitions for the two-group bus arbiter.
// Assumes: nothing beyond IEEE 1800-2017.
package arb2g_pkg;

    // Grant decision taken each cycle by the grant sequencer.
    typedef enum logic [1:0] {
        GD_KEEP    = 2'd0,
        GD_DIRECT  = 2'd1,
        GD_ASSIGN  = 2'd2,
        GD_RELEASE = 2'd3
    } grant_dec_e;

    // Bits needed to hold an index in 0..n-1 (at least one).
    function automatic int ptr_bits(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/arb2g_rr_pick.sv
// Round-robin picker: returns the first requester after position 'last',
// searching upward with wrap-around. Purely combinational.
// Assumes: last < WIDTH.
module arb2g_rr_pick #(
    parameter  int WIDTH = 4,
    localparam int LW    = arb2g_pkg::ptr_bits(WIDTH)
) (
    input  logic [WIDTH-1:0] req,
    input  logic [LW-1:0]    last,
    output logic [WIDTH-1:0] win
);

    logic found;

    // Scan from last+1 around to last, keep the first requester.
    always_comb begin
        win   = '0;
        found = 1'b0;
        for (int off = 1; off <= WIDTH; off++) begin
            int idx;
            idx = (int'(last) + off) % WIDTH;
            if (!found && req[idx]) begin
                win[idx] = 1'b1;
                found    = 1'b1;
            end
        end
    end

endmodule

// File: rtl/arb2g_stall_guard.sv
// Idle-grant watchdog. Counts cycles in which a grant is held on an idle bus
// with no owner change. Fires on the LIMIT-th such cycle and locks the owner
// out until its request goes inactive for a clock.
// Assumes: gnt is one-hot or zero, and gnt_next is the registered grant's next value.
module arb2g_stall_guard #(
    parameter  int N_M   = 10,
    parameter  int LIMIT = 16,
    localparam int CW    = $clog2(LIMIT + 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           idle,
    input  logic [N_M-1:0] req,
    input  logic [N_M-1:0] gnt,
    input  logic [N_M-1:0] gnt_next,
    output logic [N_M-1:0] locked,
    output logic           fire
);

    logic [CW-1:0]  cnt;
    logic [N_M-1:0] lock_next;

    // Timeout strikes on the last cycle of the allowed idle window.
    assign fire = (|gnt) && idle && (cnt == CW'(LIMIT - 1));

    // Per-master lockout: set by a timeout on the owner, cleared by a released request.
    for (genvar i = 0; i < N_M; i++) begin : g_lock
        assign lock_next[i] = (locked[i] | (fire & gnt[i])) & req[i];
    end

    // Idle-grant counter, restarted by bus activity or an owner change.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if ((|gnt) && idle && (gnt_next == gnt)) begin
            cnt <= cnt + 1'b1;
        end else begin
            cnt <= '0;
        end
    end

    // Lockout register.
    always_ff @(posedge clk) begin
        if (!rst_n) locked <= '0;
        else        locked <= lock_next;
    end

    assert_cnt_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cnt < CW'(LIMIT));

    assert_cnt_restart_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !idle |=> (cnt == '0));

endmodule

// File: rtl/arb2g_grant_seq.sv
// Grant sequencer. Holds the registered grant and decides each cycle whether
// to keep it, swap directly (FRAME# low), assign from empty, or release.
// Enforces the minimum hold on an idle bus.
// Assumes: target is one-hot or zero, and fire is the watchdog's timeout strobe.
module arb2g_grant_seq #(
    parameter  int N_M      = 10,
    parameter  int MIN_HOLD = 2,
    localparam int HW       = $clog2(MIN_HOLD + 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           frame_n,
    input  logic           fire,
    input  logic [N_M-1:0] target,
    output logic [N_M-1:0] gnt,
    output logic [N_M-1:0] gnt_next
);
    import arb2g_pkg::*;

    grant_dec_e     dec;
    logic [HW-1:0]  hold;

    // Pick the action for this cycle.
    always_comb begin
        if (fire)                    dec = GD_RELEASE;
        else if (!frame_n)           dec = GD_DIRECT;
        else if (gnt == '0)          dec = GD_ASSIGN;
        else if (hold < HW'(MIN_HOLD)) dec = GD_KEEP;
        else if (target != gnt)      dec = GD_RELEASE;
        else                         dec = GD_KEEP;
    end

    // Turn the action into the next grant vector.
    always_comb begin
        unique case (dec)
            GD_DIRECT, GD_ASSIGN: gnt_next = target;
            GD_RELEASE:           gnt_next = '0;
            default:              gnt_next = gnt;
        endcase
    end

    // Grant register.
    always_ff @(posedge clk) begin
        if (!rst_n) gnt <= '0;
        else        gnt <= gnt_next;
    end

    // Count the cycles the current owner has been visible, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n)                 hold <= '0;
        else if (gnt_next == '0)    hold <= '0;
        else if (gnt_next != gnt)   hold <= HW'(1);
        else if (hold < HW'(MIN_HOLD)) hold <= hold + 1'b1;
    end

    assert_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt));

    assert_gap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt != '0 && frame_n) |=> (gnt == $past(gnt) || gnt == '0));

    assert_min_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt != '0 && $past(gnt) == '0 && frame_n) |=> (gnt == $past(gnt)));

endmodule

// File: rtl/pci_dual_group_arbiter.sv
// Two-group rotating bus arbiter. High-group masters plus one virtual slot for
// the whole low group rotate in the upper ring; low-group masters rotate in a
// second ring. Rankings move only on a FRAME# falling edge.
// Assumes: master 0 is the internal master, and all bus inputs are synchronous to clk.
module pci_dual_group_arbiter #(
    parameter int NUM_MASTERS = 10,
    parameter int IDLE_LIMIT  = 16,
    parameter int MIN_GRANT   = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NUM_MASTERS-1:0] req_n,
    input  logic                   frame_n,
    input  logic                   irdy_n,
    input  logic [NUM_MASTERS-1:0] hi_group,
    output logic [NUM_MASTERS-1:0] gnt_n
);
    localparam int N     = NUM_MASTERS;
    localparam int LW_HI = arb2g_pkg::ptr_bits(N + 1);
    localparam int LW_LO = arb2g_pkg::ptr_bits(N);

    logic [N-1:0]     req, eff_req, lo_req, lo_win, target, gnt, gnt_next, locked;
    logic [N:0]       hi_req, hi_win;
    logic [LW_HI-1:0] hi_ptr;
    logic [LW_LO-1:0] lo_ptr, owner;
    logic             idle, fire, frame_q, start;

    assign req     = ~req_n;
    assign idle    = frame_n && irdy_n;
    assign eff_req = req & ~locked;
    assign lo_req  = eff_req & ~hi_group;
    assign hi_req  = {|lo_req, eff_req & hi_group};
    assign start   = frame_q && !frame_n;

    arb2g_rr_pick #(.WIDTH(N + 1)) u_hi_ring (
        .req (hi_req),
        .last(hi_ptr),
        .win (hi_win)
    );

    arb2g_rr_pick #(.WIDTH(N)) u_lo_ring (
        .req (lo_req),
        .last(lo_ptr),
        .win (lo_win)
    );

    // Winner: the low ring's pick if the virtual slot won the upper ring.
    assign target = hi_win[N] ? lo_win : hi_win[N-1:0];

    arb2g_grant_seq #(.N_M(N), .MIN_HOLD(MIN_GRANT)) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .frame_n (frame_n),
        .fire    (fire),
        .target  (target),
        .gnt     (gnt),
        .gnt_next(gnt_next)
    );

    arb2g_stall_guard #(.N_M(N), .LIMIT(IDLE_LIMIT)) u_guard (
        .clk     (clk),
        .rst_n   (rst_n),
        .idle    (idle),
        .req     (req),
        .gnt     (gnt),
        .gnt_next(gnt_next),
        .locked  (locked),
        .fire    (fire)
    );

    // Index of the current grant owner.
    always_comb begin
        owner = '0;
        for (int i = 0; i < N; i++) begin
            if (gnt[i]) owner = LW_LO'(i);
        end
    end

    // Rotation pointers, moved only when a transaction starts.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_ptr  <= LW_HI'(N);
            lo_ptr  <= LW_LO'(N - 1);
            frame_q <= 1'b1;
        end else begin
            frame_q <= frame_n;
            if (start && (|gnt)) begin
                if (hi_group[owner]) begin
                    hi_ptr <= LW_HI'(owner);
                end else begin
                    hi_ptr <= LW_HI'(N);
                    lo_ptr <= owner;
                end
            end
        end
    end

    assign gnt_n = ~gnt;

    assert_lock_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (locked & gnt) == '0);

    assert_timeout_drop_R10: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> (gnt == '0));

    assert_lo_ptr_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> $stable(lo_ptr));

endmodule

// File: tb/pci_dual_group_arbiter_test.sv
module pci_dual_group_arbiter_test;
    timeunit 1ns;
    timeprecision 1ps;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [9:0] req_n = '1;
    logic       frame_n = 1'b1;
    logic       irdy_n = 1'b1;
    logic [9:0] hi_group = 10'b0000000001;
    logic [9:0] gnt_n;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [9:0] exp_q[$];
    string      tag_q[$];

    pci_dual_group_arbiter uut (
        .clk(clk), .rst_n(rst_n), .req_n(req_n), .frame_n(frame_n),
        .irdy_n(irdy_n), .hi_group(hi_group), .gnt_n(gnt_n)
    );

    always #4 clk = ~clk;

    function automatic logic [9:0] m(input int i);
        return 10'(1) << i;
    endfunction

    task automatic check(input logic [9:0] act, input logic [9:0] exp, input string tg);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: grant actual=%b expected=%b", tg, act, exp);
        end
    endtask

    // Driver: apply one cycle of stimulus and queue the grant expected after the edge.
    task automatic drive(input logic [9:0] rq, input logic fr, input logic ir,
                         input logic [9:0] ex, input string tg);
        @(negedge clk);
        #1;
        req_n   = ~rq;
        frame_n = fr;
        irdy_n  = ir;
        exp_q.push_back(ex);
        tag_q.push_back(tg);
    endtask

    // Monitor: pop and compare one item per cycle, and check one-hot.
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            logic [9:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(~gnt_n, e, t);
            checks++;
            if ($countones(~gnt_n) > 1) begin
                errors++;
                $display("FAIL R2: grant actual=%b expected=at most one low", ~gnt_n);
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(~gnt_n, 10'b0, "R1 during reset");
        rst_n = 1'b1;

        // A: default groups, bridge alternates with low group (R3, R5, R9, R7)
        drive(10'b0, 1, 1, 10'b0, "R1 after reset");
        drive(m(0)|m(1)|m(2), 1, 1, m(0), "R3 bridge first");
        drive(m(0)|m(1)|m(2), 0, 1, m(0), "R5 bridge starts");
        drive(m(1)|m(2), 0, 1, m(1), "R9 direct swap to m1");
        drive(m(1)|m(2), 1, 0, m(1), "R7 hold m1");
        drive(m(1)|m(2), 0, 1, m(1), "R5 m1 starts");
        drive(m(0)|m(2), 0, 1, m(0), "R3 bridge after low turn");
        drive(m(0)|m(2), 1, 1, m(0), "R7 hold bridge");
        drive(m(0)|m(2), 0, 1, m(0), "R5 bridge starts again");
        drive(m(1)|m(2), 0, 1, m(2), "R5 m1 now lowest in low ring");
        drive(m(1)|m(2), 1, 1, m(2), "R7 hold m2");
        drive(m(1)|m(2), 1, 1, m(2), "R5 no re-rank without start");
        drive(10'b0, 1, 1, 10'b0, "R8 release");
        drive(10'b0, 1, 1, 10'b0, "R1 stays empty");

        // B: preemption with idle gap (R6, R8, R7)
        drive(m(3), 1, 1, m(3), "R6 m3 granted");
        drive(m(3)|m(2), 1, 1, m(3), "R7 m3 held before preempt");
        drive(m(3)|m(2), 1, 1, 10'b0, "R8 gap before new owner");
        drive(m(3)|m(2), 1, 1, m(2), "R6 m2 preempts");
        drive(m(3)|m(2), 1, 1, m(2), "R7 hold m2");
        drive(10'b0, 1, 1, 10'b0, "R8 release m2");

        // D: idle timeout and lockout (R10, R11)
        drive(m(4), 1, 1, m(4), "R10 m4 granted");
        for (int k = 1; k <= 15; k++) drive(m(4), 1, 1, m(4), "R10 m4 within window");
        drive(m(4), 1, 1, 10'b0, "R10 m4 withdrawn");
        drive(m(4)|m(5), 1, 1, m(5), "R11 locked m4 skipped");
        drive(m(4), 1, 1, m(5), "R7 hold m5");
        drive(m(4), 1, 1, 10'b0, "R11 no grant to locked m4");
        drive(m(4), 1, 1, 10'b0, "R11 still locked");
        drive(10'b0, 1, 1, 10'b0, "R11 request released");
        drive(m(4), 1, 1, m(4), "R11 m4 granted after release");
        drive(m(4), 0, 1, m(4), "R5 m4 starts");
        drive(10'b0, 1, 1, 10'b0, "R8 release m4");

        // E: IRDY# activity restarts the idle count (R12)
        drive(m(6), 1, 1, m(6), "R5 low ring after m4 picks m6");
        for (int k = 1; k <= 10; k++) drive(m(6), 1, 1, m(6), "R12 m6 idle count");
        drive(m(6), 1, 0, m(6), "R12 busy cycle");
        for (int k = 12; k <= 26; k++) drive(m(6), 1, 1, m(6), "R12 count restarted");
        drive(m(6), 1, 1, 10'b0, "R10 m6 withdrawn");
        drive(10'b0, 1, 1, 10'b0, "R11 m6 released");
        hi_group = 10'b1111111111;

        // F: all high, then all low: plain round-robin (R4)
        drive(m(1)|m(3)|m(7), 1, 1, m(1), "R4 m1 first");
        drive(m(1)|m(3)|m(7), 0, 1, m(1), "R4 m1 starts");
        drive(m(1)|m(3)|m(7), 0, 1, m(3), "R4 next m3");
        drive(m(1)|m(3)|m(7), 1, 0, m(3), "R7 hold m3");
        drive(m(1)|m(3)|m(7), 0, 1, m(3), "R4 m3 starts");
        drive(m(1)|m(3)|m(7), 0, 1, m(7), "R4 next m7");
        drive(m(1)|m(3)|m(7), 1, 0, m(7), "R7 hold m7");
        drive(m(1)|m(3)|m(7), 0, 1, m(7), "R4 m7 starts");
        drive(m(1)|m(3)|m(7), 0, 1, m(1), "R4 wrap to m1");
        drive(10'b0, 1, 1, m(1), "R7 hold m1");
        drive(10'b0, 1, 1, 10'b0, "R8 release m1");
        hi_group = 10'b0000000000;
        drive(m(0)|m(5), 1, 1, m(5), "R4 all low picks m5");
        drive(m(0)|m(5), 0, 1, m(5), "R4 m5 starts");
        drive(m(0)|m(5), 0, 1, m(0), "R4 wrap to bridge");
        drive(10'b0, 1, 1, m(0), "R7 hold bridge");
        drive(10'b0, 1, 1, 10'b0, "R8 release bridge");

        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule